// File: doc/BRIEF.md
# Cascaded Interrupt Priority Encoder

This block gathers interrupt requests from three prioritised groups (critical, main and peripheral) and from a fourth group of DMA-task events. It reduces them to one encoded status word and a single interrupt line to the processor. Each group has its own valid flag and index field in the status word, so an interrupt handler can read one register and learn the winning source of every group at once.

The groups are cascaded. Peripheral slot 0 stands for "some unmasked DMA event is pending". Critical slot 2 stands for "a high-priority peripheral source is active". Main slot 4 stands for "a low-priority peripheral source is active". A parameter marks which peripheral sources count as high priority. Within each group the lowest-numbered active and unmasked source wins. Software reads and writes the mask registers and the DMA pending register over a simple word-addressed register bus.

The status word and the interrupt line are registered. They show the state of the sources and of the internal pending bits one clock later.

Top module: `irqenc_top`

## Requirements
- R1: Status word at bus address 0. Bit 10 is the critical valid flag and bits 9:8 the critical index. Bit 21 is the main valid flag and bits 20:16 the main index. Bit 29 is the peripheral valid flag and bits 28:24 the peripheral index. All other bits read 0.
- R2: Within each group, the lowest-numbered active and unmasked source is the one encoded.
- R3: A mask bit of 1 disables its source. Main source n uses bit 16-n of address 1. Peripheral source n uses bit 31-n of address 2. DMA source n uses bit n of address 3.
- R4: Critical slot 2 is active while any unmasked high-priority peripheral source is active, and the external critical input 2 is ignored. While such a source is active, the peripheral field shows the lowest high-priority source.
- R5: Main slot 4 is active while any unmasked peripheral source outside the high-priority set is active, and the external main input 4 is ignored. Main mask bit 12 gates this slot.
- R6: Peripheral slot 0 is active while any DMA pending bit is set and unmasked, and the external peripheral input 0 is ignored.
- R7: A high cycle on a DMA request input sets its pending bit, also while that source is masked. Writing 1 to a bit at address 4 clears that bit. A new event in the same cycle wins over the clear. Address 4 reads back the pending bits.
- R8: Critical slots 0, 1 and 3 latch on a rising edge of their input, and no mask applies to them. A bus write to address 0 with bit 10 set clears the critical slot the status currently shows. The write has no effect when that slot is 2.
- R9: The CPU interrupt output is high exactly when at least one group valid flag in the status word is set.
- R10: After reset, address 1 reads 0x0001FFFF, address 2 reads 0xFFFFFF00 and address 3 reads 0xFFFFFFFF. The pending bits, the status word and the interrupt output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| crit_req | input | 4 | Critical sources, rising-edge captured (input 2 unused) |
| main_req | input | MAIN_N | Main sources, level (input 4 unused) |
| periph_req | input | PERIPH_N | Peripheral sources, level (input 0 unused) |
| dma_req | input | DMA_N | DMA-task event pulses |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from the address |
| cpu_irq | output | 1 | Interrupt line to the processor |

## Verification
On every cycle, the assertions check the following. The interrupt line agrees with the three valid flags. A critical index of 2 or a main index of 4 never appears without a valid peripheral field. The peripheral field then names a high-priority source, and every index lies inside its group. A W1C write and a critical acknowledge each remove the bits they target. The bench scenarios are the only place where the fixed-order selection, the mask bit positions, the ignored external cascade inputs, edge capture without re-triggering, set-over-clear and the reset values can be seen.

// File: rtl/irqenc_pkg.sv
package irqenc_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_STATUS = 3'd0,
    A_MMASK  = 3'd1,
    A_PMASK  = 3'd2,
    A_DMASK  = 3'd3,
    A_DPEND  = 3'd4
  } reg_addr_e;

  // cascade slot numbers
  localparam int CRIT_HP_SLOT    = 2;
  localparam int MAIN_LP_SLOT    = 4;
  localparam int PERIPH_DMA_SLOT = 0;
  localparam int CRIT_N          = 4;

  // status word field positions
  localparam int ST_CRIT_V = 10;
  localparam int ST_CRIT_I = 8;
  localparam int ST_MAIN_V = 21;
  localparam int ST_MAIN_I = 16;
  localparam int ST_PER_V  = 29;
  localparam int ST_PER_I  = 24;

  // {found, index} of lowest set bit
  function automatic logic [5:0] lowest_set(input logic [31:0] v);
    logic [5:0] r;
    r = 6'd0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = {1'b1, 5'(i)};
    end
    return r;
  endfunction

  function automatic int main_mask_bit(input int n);
    return 16 - n;
  endfunction

  function automatic int periph_mask_bit(input int n);
    return 31 - n;
  endfunction

  function automatic logic [31:0] main_impl(input int n);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < n; i++) r[main_mask_bit(i)] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] periph_impl(input int n);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < n; i++) r[periph_mask_bit(i)] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] status_pack(
    input logic cv, input logic [1:0] ci,
    input logic mv, input logic [4:0] mi,
    input logic pv, input logic [4:0] pi);
    logic [31:0] s;
    s = '0;
    s[ST_CRIT_V] = cv;
    s[ST_CRIT_I +: 2] = cv ? ci : 2'd0;
    s[ST_MAIN_V] = mv;
    s[ST_MAIN_I +: 5] = mv ? mi : 5'd0;
    s[ST_PER_V] = pv;
    s[ST_PER_I +: 5] = pv ? pi : 5'd0;
    return s;
  endfunction

endpackage

// File: rtl/irqenc_prio.sv
module irqenc_prio #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic         valid,
  output logic [4:0]   idx
);
  logic [31:0] wide;
  logic [5:0]  hit;

  always_comb begin
    wide  = 32'(req);
    hit   = irqenc_pkg::lowest_set(wide);
    valid = hit[5];
    idx   = hit[4:0];
  end
endmodule

// File: rtl/irqenc_regs.sv
module irqenc_regs
  import irqenc_pkg::*;
#(
  parameter int MAIN_N   = 17,
  parameter int PERIPH_N = 24,
  parameter int DMA_N    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  input  logic [DMA_N-1:0]    dma_req,
  input  logic [CRIT_N-1:0]   crit_req,
  input  logic                ack_fire,
  input  logic [1:0]          ack_idx,
  output logic [31:0]         main_mask,
  output logic [31:0]         periph_mask,
  output logic [DMA_N-1:0]    dma_mask,
  output logic [DMA_N-1:0]    dma_pend,
  output logic [CRIT_N-1:0]   crit_pend,
  output logic [CRIT_N-1:0]   crit_rise
);
  localparam logic [31:0] MAIN_IMPL   = main_impl(MAIN_N);
  localparam logic [31:0] PERIPH_IMPL = periph_impl(PERIPH_N);
  localparam logic [CRIT_N-1:0] CRIT_EXT = ~(CRIT_N'(1) << CRIT_HP_SLOT);

  logic [CRIT_N-1:0] crit_prev;
  logic [CRIT_N-1:0] crit_clr;
  logic [DMA_N-1:0]  dma_clr;
  logic              wr_mm, wr_pm, wr_dm, wr_dp;

  always_comb begin
    wr_mm    = bus_wr && (bus_addr == A_MMASK);
    wr_pm    = bus_wr && (bus_addr == A_PMASK);
    wr_dm    = bus_wr && (bus_addr == A_DMASK);
    wr_dp    = bus_wr && (bus_addr == A_DPEND);
    dma_clr  = wr_dp ? bus_wdata[DMA_N-1:0] : '0;
    crit_clr = ack_fire ? (CRIT_N'(1) << ack_idx) : '0;
    crit_rise = crit_req & ~crit_prev & CRIT_EXT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_mask   <= MAIN_IMPL;
      periph_mask <= PERIPH_IMPL;
      dma_mask    <= '1;
    end else begin
      if (wr_mm) main_mask   <= bus_wdata & MAIN_IMPL;
      if (wr_pm) periph_mask <= bus_wdata & PERIPH_IMPL;
      if (wr_dm) dma_mask    <= bus_wdata[DMA_N-1:0];
    end
  end

  // pending bits: a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_pend  <= '0;
      crit_pend <= '0;
      crit_prev <= '0;
    end else begin
      dma_pend  <= (dma_pend & ~dma_clr) | dma_req;
      crit_pend <= (crit_pend & ~crit_clr) | crit_rise;
      crit_prev <= crit_req;
    end
  end
endmodule

// File: rtl/irqenc_cascade.sv
module irqenc_cascade
  import irqenc_pkg::*;
#(
  parameter int          MAIN_N   = 17,
  parameter int          PERIPH_N = 24,
  parameter int          DMA_N    = 32,
  parameter logic [31:0] HP_SET   = 32'h0000_000E
) (
  input  logic [MAIN_N-1:0]   main_req,
  input  logic [PERIPH_N-1:0] periph_req,
  input  logic [DMA_N-1:0]    dma_pend,
  input  logic [DMA_N-1:0]    dma_mask,
  input  logic [31:0]         main_mask,
  input  logic [31:0]         periph_mask,
  input  logic [CRIT_N-1:0]   crit_pend,
  output logic [CRIT_N-1:0]   crit_vec,
  output logic [MAIN_N-1:0]   main_vec,
  output logic [PERIPH_N-1:0] periph_vec,
  output logic [PERIPH_N-1:0] periph_hp_vec,
  output logic                hp_any,
  output logic                lp_any,
  output logic                dma_any
);
  localparam logic [PERIPH_N-1:0] HP = HP_SET[PERIPH_N-1:0] &
                                       ~(PERIPH_N'(1) << PERIPH_DMA_SLOT);

  assign dma_any = |(dma_pend & ~dma_mask);

  for (genvar n = 0; n < PERIPH_N; n++) begin : g_per
    if (n == PERIPH_DMA_SLOT) begin : g_dma
      assign periph_vec[n] = dma_any & ~periph_mask[periph_mask_bit(n)];
    end else begin : g_ext
      assign periph_vec[n] = periph_req[n] & ~periph_mask[periph_mask_bit(n)];
    end
  end

  assign periph_hp_vec = periph_vec & HP;
  assign hp_any        = |periph_hp_vec;
  assign lp_any        = |(periph_vec & ~HP);

  for (genvar n = 0; n < MAIN_N; n++) begin : g_main
    if (n == MAIN_LP_SLOT) begin : g_lp
      assign main_vec[n] = lp_any & ~main_mask[main_mask_bit(n)];
    end else begin : g_ext
      assign main_vec[n] = main_req[n] & ~main_mask[main_mask_bit(n)];
    end
  end

  for (genvar n = 0; n < CRIT_N; n++) begin : g_crit
    if (n == CRIT_HP_SLOT) begin : g_hp
      assign crit_vec[n] = hp_any;
    end else begin : g_ext
      assign crit_vec[n] = crit_pend[n];
    end
  end
endmodule

// File: rtl/irqenc_top.sv
module irqenc_top
  import irqenc_pkg::*;
#(
  parameter int          MAIN_N   = 17,
  parameter int          PERIPH_N = 24,
  parameter int          DMA_N    = 32,
  parameter logic [31:0] HP_SET   = 32'h0000_000E
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [3:0]          crit_req,
  input  logic [MAIN_N-1:0]   main_req,
  input  logic [PERIPH_N-1:0] periph_req,
  input  logic [DMA_N-1:0]    dma_req,
  input  logic                bus_wr,
  input  logic [2:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                cpu_irq
);
  logic [31:0]         main_mask, periph_mask;
  logic [DMA_N-1:0]    dma_mask, dma_pend;
  logic [CRIT_N-1:0]   crit_pend, crit_rise, crit_vec;
  logic [MAIN_N-1:0]   main_vec;
  logic [PERIPH_N-1:0] periph_vec, periph_hp_vec;
  logic                hp_any, lp_any, dma_any;
  logic                c_v, m_v, p_v, phv;
  logic [4:0]          c_i, m_i, p_i, phi;
  logic [31:0]         status_next, status_q;
  logic                ack_fire;
  logic [31:0]         dma_pend_x, dma_req_x;

  // acknowledge targets the critical slot currently shown
  assign ack_fire = bus_wr && (bus_addr == A_STATUS) && bus_wdata[ST_CRIT_V] &&
                    status_q[ST_CRIT_V] &&
                    (status_q[ST_CRIT_I +: 2] != 2'(CRIT_HP_SLOT));

  irqenc_regs #(.MAIN_N(MAIN_N), .PERIPH_N(PERIPH_N), .DMA_N(DMA_N)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .dma_req(dma_req), .crit_req(crit_req),
    .ack_fire(ack_fire), .ack_idx(status_q[ST_CRIT_I +: 2]),
    .main_mask(main_mask), .periph_mask(periph_mask), .dma_mask(dma_mask),
    .dma_pend(dma_pend), .crit_pend(crit_pend), .crit_rise(crit_rise)
  );

  irqenc_cascade #(.MAIN_N(MAIN_N), .PERIPH_N(PERIPH_N), .DMA_N(DMA_N),
                   .HP_SET(HP_SET)) u_casc (
    .main_req(main_req), .periph_req(periph_req), .dma_pend(dma_pend),
    .dma_mask(dma_mask), .main_mask(main_mask), .periph_mask(periph_mask),
    .crit_pend(crit_pend), .crit_vec(crit_vec), .main_vec(main_vec),
    .periph_vec(periph_vec), .periph_hp_vec(periph_hp_vec),
    .hp_any(hp_any), .lp_any(lp_any), .dma_any(dma_any)
  );

  irqenc_prio #(.N(CRIT_N))   u_pc  (.req(crit_vec),      .valid(c_v), .idx(c_i));
  irqenc_prio #(.N(MAIN_N))   u_pm  (.req(main_vec),      .valid(m_v), .idx(m_i));
  irqenc_prio #(.N(PERIPH_N)) u_pp  (.req(periph_vec),    .valid(p_v), .idx(p_i));
  irqenc_prio #(.N(PERIPH_N)) u_php (.req(periph_hp_vec), .valid(phv), .idx(phi));

  always_comb begin
    status_next = status_pack(c_v, c_i[1:0], m_v, m_i, p_v, phv ? phi : p_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      cpu_irq  <= 1'b0;
    end else begin
      status_q <= status_next;
      cpu_irq  <= c_v | m_v | p_v;
    end
  end

  assign dma_pend_x = 32'(dma_pend);
  assign dma_req_x  = 32'(dma_req);

  always_comb begin
    case (bus_addr)
      A_STATUS: bus_rdata = status_q;
      A_MMASK:  bus_rdata = main_mask;
      A_PMASK:  bus_rdata = periph_mask;
      A_DMASK:  bus_rdata = 32'(dma_mask);
      A_DPEND:  bus_rdata = dma_pend_x;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqenc_checker.sv
module irqenc_checker #(
  parameter int          MAIN_N   = 17,
  parameter int          PERIPH_N = 24,
  parameter logic [31:0] HP_SET   = 32'h0000_000E
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_irq,
  input logic [31:0] status_q,
  input logic        bus_wr,
  input logic [2:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] dma_req_x,
  input logic [31:0] dma_pend_x,
  input logic [3:0]  crit_pend,
  input logic [3:0]  crit_rise,
  input logic        ack_fire
);
  p_irq_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq == (status_q[10] | status_q[21] | status_q[29]));

  p_crit_casc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[10] && status_q[9:8] == 2'd2) |-> status_q[29]);

  p_hp_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[10] && status_q[9:8] == 2'd2) |-> HP_SET[status_q[28:24]]);

  p_main_casc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[21] && status_q[20:16] == 5'd4) |-> status_q[29]);

  p_index_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_q[21] || 32'(status_q[20:16]) < MAIN_N) &&
    (!status_q[29] || 32'(status_q[28:24]) < PERIPH_N));

  p_dma_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd4 && dma_req_x == 32'd0)
      |=> ((dma_pend_x & $past(bus_wdata)) == 32'd0));

  p_crit_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && crit_rise == 4'd0) |=> !crit_pend[$past(status_q[9:8])]);
endmodule

bind irqenc_top irqenc_checker #(.MAIN_N(MAIN_N), .PERIPH_N(PERIPH_N),
                                 .HP_SET(HP_SET)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_irq(cpu_irq), .status_q(status_q),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .dma_req_x(dma_req_x), .dma_pend_x(dma_pend_x), .crit_pend(crit_pend),
  .crit_rise(crit_rise), .ack_fire(ack_fire)
);

// File: tb/irqenc_top_test.sv
module irqenc_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  crit_req = '0;
  logic [16:0] main_req = '0;
  logic [23:0] periph_req = '0;
  logic [31:0] dma_req = '0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cpu_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irqenc_top uut (
    .clk(clk), .rst_n(rst_n), .crit_req(crit_req), .main_req(main_req),
    .periph_req(periph_req), .dma_req(dma_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_irq(cpu_irq)
  );

  // table: main sources, peripheral sources, expected status (all masks open)
  localparam int NV = 10;
  localparam logic [16:0] T_MAIN [NV] = '{
    17'h0, 17'h00001, 17'h00088, 17'h10000, 17'h0,
    17'h0, 17'h00002, 17'h0, 17'h00010, 17'h0};
  localparam logic [23:0] T_PER [NV] = '{
    24'h0, 24'h0, 24'h0, 24'h0, 24'h000020,
    24'h000004, 24'h000204, 24'h800200, 24'h0, 24'h000001};
  localparam logic [31:0] T_EXP [NV] = '{
    32'h0000_0000, 32'h0020_0000, 32'h0023_0000, 32'h0030_0000, 32'h2524_0000,
    32'h2200_0600, 32'h2221_0600, 32'h2924_0000, 32'h0000_0000, 32'h0000_0000};
  localparam string T_TAG [NV] = '{
    "R2 idle", "R2 main0", "R2 main lowest", "R2 main16", "R5 lp cascade",
    "R4 hp cascade", "R4 hp plus main", "R5 lp lowest", "R5 ext main4 ignored",
    "R6 ext periph0 ignored"};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic read_check(input string tag, input logic [2:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic dma_pulse(input logic [31:0] v);
    @(negedge clk);
    dma_req = v;
    @(negedge clk);
    dma_req = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset values
    read_check("R10 main mask reset", 3'd1, 32'h0001_FFFF);
    read_check("R10 periph mask reset", 3'd2, 32'hFFFF_FF00);
    read_check("R10 dma mask reset", 3'd3, 32'hFFFF_FFFF);
    read_check("R10 dma pend reset", 3'd4, 32'h0);
    read_check("R10 status reset", 3'd0, 32'h0);
    check("R10 irq reset", 32'(cpu_irq), 32'h0);

    // R3 masks: main source n at bit 16-n, periph source n at bit 31-n
    main_req = 17'h00008; settle();
    read_check("R3 masked main", 3'd0, 32'h0);
    check("R9 irq low when masked", 32'(cpu_irq), 32'h0);
    bus_write(3'd1, 32'h0001_DFFF); main_req = 17'h00088; settle();
    read_check("R3 main bit13 opens src3", 3'd0, 32'h0023_0000);
    check("R9 irq high", 32'(cpu_irq), 32'h1);
    bus_write(3'd1, 32'h0001_FDFF); settle();
    read_check("R3 main bit9 opens src7", 3'd0, 32'h0027_0000);
    bus_write(3'd1, 32'h0001_FFFF); main_req = '0;
    bus_write(3'd2, 32'hFBFF_FF00); periph_req = 24'h000060; settle();
    read_check("R3 periph bit26 opens src5, main12 gates slot4", 3'd0, 32'h2500_0000);
    periph_req = '0;

    // open all masks, walk the table
    bus_write(3'd1, 32'h0); bus_write(3'd2, 32'h0); bus_write(3'd3, 32'h0);
    for (int i = 0; i < NV; i++) begin
      main_req = T_MAIN[i]; periph_req = T_PER[i];
      settle();
      read_check(T_TAG[i], 3'd0, T_EXP[i]);
    end
    main_req = '0; periph_req = '0;

    // R6 / R7 DMA cascade and W1C
    dma_pulse(32'h0010_0080); settle();
    read_check("R7 dma pend set", 3'd4, 32'h0010_0080);
    read_check("R6 dma via periph slot0", 3'd0, 32'h2024_0000);
    bus_write(3'd4, 32'h0000_0080); settle();
    read_check("R7 w1c bit7", 3'd4, 32'h0010_0000);
    read_check("R6 still pending", 3'd0, 32'h2024_0000);
    bus_write(3'd4, 32'h0010_0000); settle();
    read_check("R7 w1c bit20", 3'd4, 32'h0);
    read_check("R6 no dma", 3'd0, 32'h0);
    bus_write(3'd3, 32'h0010_0000); dma_pulse(32'h0010_0000); settle();
    read_check("R7 masked dma still pends", 3'd4, 32'h0010_0000);
    read_check("R3 dma bit20 masks", 3'd0, 32'h0);
    bus_write(3'd3, 32'h0); settle();
    read_check("R3 dma unmasked", 3'd0, 32'h2024_0000);
    bus_write(3'd4, 32'hFFFF_FFFF);
    @(negedge clk);
    dma_req = 32'h8; bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 32'h8;
    @(negedge clk);
    dma_req = '0; bus_wr = 1'b0; bus_wdata = '0;
    read_check("R7 set wins over clear", 3'd4, 32'h8);
    bus_write(3'd4, 32'h8); settle();
    read_check("R7 cleared", 3'd0, 32'h0);

    // R8 critical edge capture and acknowledge
    crit_req = 4'b0010; settle();
    read_check("R8 crit1 captured", 3'd0, 32'h0000_0500);
    crit_req = 4'b0011; settle();
    read_check("R2 crit0 beats crit1", 3'd0, 32'h0000_0400);
    bus_write(3'd0, 32'h0000_0400); settle();
    read_check("R8 ack clears crit0", 3'd0, 32'h0000_0500);
    bus_write(3'd0, 32'h0000_0400); settle();
    read_check("R8 held input no retrigger", 3'd0, 32'h0);
    crit_req = 4'b0000; settle();
    crit_req = 4'b0100; settle();
    read_check("R4 ext crit2 ignored", 3'd0, 32'h0);
    crit_req = 4'b0000;
    periph_req = 24'h000004; crit_req = 4'b1000; settle();
    read_check("R4 hp slot beats crit3", 3'd0, 32'h2200_0600);
    bus_write(3'd0, 32'h0000_0400); periph_req = '0; settle();
    read_check("R8 ack on slot2 no effect", 3'd0, 32'h0000_0700);
    bus_write(3'd0, 32'h0000_0400); settle();
    read_check("R8 ack crit3", 3'd0, 32'h0);
    check("R9 irq low at end", 32'(cpu_irq), 32'h0);
    crit_req = '0;

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule